// File: doc/BRIEF.md
# Audio Port Clock Generator

This block makes the bit clock and the left/right frame clock of a serial audio port from the master clock whenever the port owns the clocks. A 3-bit ratio code says how many master-clock cycles make up one sample period. From that code the block derives a bit clock with 64 bit clocks per sample frame. The frame clock changes every 32 bit clocks. In DSP framing it becomes a pulse one bit clock wide instead. When the code selects slave operation, both output enables go low and the clocks arriving from outside are passed to the rest of the port.

The data formatter gets two single-cycle strobes in the master-clock domain: one at each falling edge of the bit clock, where data and frame transitions occur, and one at the falling edge that opens a frame. It also gets a bit-clock line and a frame-clock line that always carry the clocks the port is using, generated or external. Optional inversion of the bit clock applies in both modes. A polarity control flips the generated frame-clock level outside DSP framing. A new ratio code takes effect only where a frame ends, so a frame is never cut short.

Top module: `audclk_gen`

## Requirements
- R1: While `rstN` is low, both output enables, both pin outputs and both strobes are 0.
- R2: Ratio code 1, 2, 3, 4, 5, 6 selects master operation with a bit-clock period of 2, 3, 4, 6, 8, 12 master-clock cycles, and both enables are 1. Codes 0 and 7 select slave operation.
- R3: In master operation the non-inverted bit clock is high for floor(period/2) master cycles and low for the rest of each period.
- R4: A master frame lasts 64 bit-clock periods (64 × period master cycles between frame-start strobes). The frame clock changes level only in a cycle that carries the bit-fall strobe.
- R5: Outside DSP framing (`dspFormat`=0), the generated frame clock equals `lrPolarity` for the first 32 bit clocks of a frame and its complement for the last 32.
- R6: With `dspFormat`=1, the generated frame clock is 1 during the first bit clock of each frame only, whatever `lrPolarity` is.
- R7: `bclkInvert`=1 inverts the bit clock on `bclkPin` and `bclkLine` in master operation, and inverts `extBclk` on `bclkLine` in slave operation.
- R8: `bitFallStb` is high for one master cycle in the first cycle in which the non-inverted bit clock is low after being high. `frameStartStb` is high only together with `bitFallStb`, on bit 0 of a frame. There are 64 bit-fall strobes per frame.
- R9: A change of ratio code during master operation takes effect after the last cycle of the current frame. This holds for a change to another ratio and for a change to slave operation.
- R10: In slave operation both enables, both pins and both strobes are 0. `lrclkLine` follows `extLrclk`.
- R11: When a master code is applied during slave operation, `frameStartStb` and both enables are 1 after the second rising master-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ratioCode | input | 3 | Master-clock ratio code, 0 and 7 mean slave |
| bclkInvert | input | 1 | Invert the bit clock |
| lrPolarity | input | 1 | Invert the generated frame-clock level (non-DSP) |
| dspFormat | input | 1 | Generate a one-bit frame pulse instead of a level |
| extBclk | input | 1 | Bit clock from outside, used in slave operation |
| extLrclk | input | 1 | Frame clock from outside, used in slave operation |
| bclkPin | output | 1 | Bit-clock value for the pad driver |
| bclkOe | output | 1 | Bit-clock pad output enable |
| lrclkPin | output | 1 | Frame-clock value for the pad driver |
| lrclkOe | output | 1 | Frame-clock pad output enable |
| bclkLine | output | 1 | Bit clock in use by the port |
| lrclkLine | output | 1 | Frame clock in use by the port |
| bitFallStb | output | 1 | One-cycle strobe at each bit-clock falling edge |
| frameStartStb | output | 1 | One-cycle strobe at the falling edge opening a frame |

## Verification
Every generated output sits one register behind the counter state. A master code applied in slave operation therefore shows up as a frame-start strobe after the second rising edge. A code change at the end of a frame lands exactly 64 × period rising edges after the rising edge whose frame-start strobe the bench observed. The bench drives inputs and samples outputs on falling clock edges. It anchors every measurement on an observed frame-start strobe and counts whole frames from there, so the R9 gap length and the slave-switch edge count are compared as exact cycle numbers. Level and duty checks count high cycles over one complete frame. Alignment checks compare each sample with the one before it.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

  localparam int CODE_W = 3;

  // Strobes and levels the counter side hands to the output side.
  typedef struct packed {
    logic master;      // a master ratio is active
    logic bitFall;     // first cycle of a bit period (bit clock low)
    logic frameStart;  // bitFall on bit 0 of a frame
    logic bclkHigh;    // bit clock in its high phase
    logic secondHalf;  // bit index in the upper half of the frame
    logic firstBit;    // bit index is 0
  } clkStb_t;

  // Master cycles per bit clock; 0 means slave operation.
  function automatic int unsigned codeToDiv(input logic [CODE_W-1:0] code);
    case (code)
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 4;
      3'd4:    return 6;
      3'd5:    return 8;
      3'd6:    return 12;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/audclk_ctrl.sv
module audclk_ctrl
  import audclk_pkg::*;
#(
  parameter int FRAME_BITS = 64,
  parameter int CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] ratioCode,
  output clkStb_t           stb
);

  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam int HALF  = FRAME_BITS / 2;

  logic [CODE_W-1:0] activeCode;
  logic [CNT_W-1:0]  phaseCnt;
  logic [CNT_W-1:0]  divLen;
  logic [CNT_W-1:0]  highLen;
  logic [CNT_W-1:0]  lowLen;
  logic [IDX_W-1:0]  bitIdx;
  logic              isMaster;
  logic              phaseWrap;
  logic              frameWrap;

  always_comb begin
    divLen    = CNT_W'(codeToDiv(activeCode));
    highLen   = divLen >> 1;
    lowLen    = divLen - highLen;
    isMaster  = (divLen != '0);
    phaseWrap = (phaseCnt == divLen - CNT_W'(1));
    frameWrap = phaseWrap && (bitIdx == IDX_W'(FRAME_BITS - 1));
  end

  // Counters; the ratio code is only sampled while idle or at frame end.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCode <= '0;
      phaseCnt   <= '0;
      bitIdx     <= '0;
    end else if (!isMaster) begin
      activeCode <= ratioCode;
      phaseCnt   <= '0;
      bitIdx     <= '0;
    end else if (phaseWrap) begin
      phaseCnt <= '0;
      if (frameWrap) begin
        bitIdx     <= '0;
        activeCode <= ratioCode;
      end else begin
        bitIdx <= bitIdx + IDX_W'(1);
      end
    end else begin
      phaseCnt <= phaseCnt + CNT_W'(1);
    end
  end

  always_comb begin
    stb.master     = isMaster;
    stb.bitFall    = isMaster && (phaseCnt == '0);
    stb.frameStart = isMaster && (phaseCnt == '0) && (bitIdx == '0);
    stb.bclkHigh   = isMaster && (phaseCnt >= lowLen);
    stb.secondHalf = isMaster && (bitIdx >= IDX_W'(HALF));
    stb.firstBit   = isMaster && (bitIdx == '0);
  end

  // R9: the active ratio is held until the frame wraps
  assert_code_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    isMaster && !frameWrap |=> $stable(activeCode));

  // R2: phase counter never leaves the bit period
  assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    isMaster |-> phaseCnt < divLen);

  // R4: the frame half changes only on a bit-clock fall
  assert_half_on_fall_R4: assert property (@(posedge clk) disable iff (!rstN)
    isMaster && $past(isMaster) && (stb.secondHalf != $past(stb.secondHalf))
      |-> stb.bitFall);

endmodule

// File: rtl/audclk_dp.sv
module audclk_dp
  import audclk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  clkStb_t stb,
  input  logic    bclkInvert,
  input  logic    lrPolarity,
  input  logic    dspFormat,
  input  logic    extBclk,
  input  logic    extLrclk,
  output logic    bclkPin,
  output logic    bclkOe,
  output logic    lrclkPin,
  output logic    lrclkOe,
  output logic    bclkLine,
  output logic    lrclkLine,
  output logic    bitFallStb,
  output logic    frameStartStb
);

  logic masterQ;
  logic bclkGenQ;
  logic lrGenQ;
  logic bitFallQ;
  logic frameStartQ;
  logic lrNext;

  always_comb begin
    if (!stb.master)   lrNext = 1'b0;
    else if (dspFormat) lrNext = stb.firstBit;
    else               lrNext = stb.secondHalf ^ lrPolarity;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      masterQ     <= 1'b0;
      bclkGenQ    <= 1'b0;
      lrGenQ      <= 1'b0;
      bitFallQ    <= 1'b0;
      frameStartQ <= 1'b0;
    end else begin
      masterQ     <= stb.master;
      bclkGenQ    <= stb.bclkHigh;
      lrGenQ      <= lrNext;
      bitFallQ    <= stb.bitFall;
      frameStartQ <= stb.frameStart;
    end
  end

  always_comb begin
    bclkOe        = masterQ;
    lrclkOe       = masterQ;
    bclkPin       = masterQ & (bclkGenQ ^ bclkInvert);
    lrclkPin      = masterQ & lrGenQ;
    bclkLine      = masterQ ? (bclkGenQ ^ bclkInvert) : (extBclk ^ bclkInvert);
    lrclkLine     = masterQ ? lrGenQ : extLrclk;
    bitFallStb    = bitFallQ;
    frameStartStb = frameStartQ;
  end

  // R8: a frame start is always a bit-clock fall
  assert_frame_on_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameStartStb |-> bitFallStb);

  // R8: the fall strobe marks a real high-to-low step of the bit clock
  assert_fall_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    bitFallStb && $past(masterQ) |-> !bclkGenQ && $past(bclkGenQ));

  // R10: no strobes while the pads are released
  assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !bclkOe |-> !bitFallStb && !frameStartStb);

  // R2: both pad enables move together
  assert_oe_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    bclkOe == lrclkOe);

endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
  import audclk_pkg::*;
#(
  parameter int FRAME_BITS = 64,
  parameter int CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] ratioCode,
  input  logic              bclkInvert,
  input  logic              lrPolarity,
  input  logic              dspFormat,
  input  logic              extBclk,
  input  logic              extLrclk,
  output logic              bclkPin,
  output logic              bclkOe,
  output logic              lrclkPin,
  output logic              lrclkOe,
  output logic              bclkLine,
  output logic              lrclkLine,
  output logic              bitFallStb,
  output logic              frameStartStb
);

  clkStb_t stb;

  audclk_ctrl #(
    .FRAME_BITS(FRAME_BITS),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ratioCode(ratioCode),
    .stb      (stb)
  );

  audclk_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .bclkInvert   (bclkInvert),
    .lrPolarity   (lrPolarity),
    .dspFormat    (dspFormat),
    .extBclk      (extBclk),
    .extLrclk     (extLrclk),
    .bclkPin      (bclkPin),
    .bclkOe       (bclkOe),
    .lrclkPin     (lrclkPin),
    .lrclkOe      (lrclkOe),
    .bclkLine     (bclkLine),
    .lrclkLine    (lrclkLine),
    .bitFallStb   (bitFallStb),
    .frameStartStb(frameStartStb)
  );

endmodule

// File: tb/audclk_gen_bench.sv
module audclk_gen_bench;

  typedef struct packed {
    logic [2:0] code;
    logic       dsp;
    logic       pol;
    logic       inv;
    logic [3:0] div;
    logic [3:0] hi;
  } vec_t;

  // code, dsp, pol, inv, expected period, expected high cycles
  localparam vec_t VECS [8] = '{
    '{3'd1, 1'b0, 1'b0, 1'b0, 4'd2,  4'd1},
    '{3'd2, 1'b0, 1'b1, 1'b0, 4'd3,  4'd1},
    '{3'd3, 1'b1, 1'b0, 1'b0, 4'd4,  4'd2},
    '{3'd4, 1'b0, 1'b0, 1'b1, 4'd6,  4'd3},
    '{3'd5, 1'b1, 1'b1, 1'b0, 4'd8,  4'd4},
    '{3'd6, 1'b0, 1'b1, 1'b1, 4'd12, 4'd6},
    '{3'd2, 1'b1, 1'b0, 1'b1, 4'd3,  4'd1},
    '{3'd1, 1'b1, 1'b1, 1'b1, 4'd2,  4'd1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] ratioCode = 3'd0;
  logic       bclkInvert = 1'b0;
  logic       lrPolarity = 1'b0;
  logic       dspFormat = 1'b0;
  logic       extBclk = 1'b0;
  logic       extLrclk = 1'b0;
  logic       bclkPin, bclkOe, lrclkPin, lrclkOe;
  logic       bclkLine, lrclkLine, bitFallStb, frameStartStb;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  audclk_gen u_audclk_gen (
    .clk(clk), .rstN(rstN), .ratioCode(ratioCode), .bclkInvert(bclkInvert),
    .lrPolarity(lrPolarity), .dspFormat(dspFormat), .extBclk(extBclk),
    .extLrclk(extLrclk), .bclkPin(bclkPin), .bclkOe(bclkOe),
    .lrclkPin(lrclkPin), .lrclkOe(lrclkOe), .bclkLine(bclkLine),
    .lrclkLine(lrclkLine), .bitFallStb(bitFallStb),
    .frameStartStb(frameStartStb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Returns negedges until the next observed frame-start strobe.
  task automatic countToFrame(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!frameStartStb && n < 5000);
  endtask

  task automatic measureFrame(input vec_t v);
    int n = 0, falls = 0, highs = 0, lrHighs = 0;
    int edgeBad = 0, lrBad = 0, lineBad = 0, oeBad = 0;
    logic raw, prevRaw, prevLr, startLr;
    startLr = lrclkPin;
    prevRaw = 1'b0;
    prevLr  = 1'b0;
    do begin
      raw = bclkPin ^ v.inv;
      if (bitFallStb) falls++;
      if (n > 0 && bitFallStb && !(!raw && prevRaw)) edgeBad++;
      if (n > 0 && lrclkPin != prevLr && !bitFallStb) lrBad++;
      if (bclkLine != bclkPin || lrclkLine != lrclkPin) lineBad++;
      if (!bclkOe || !lrclkOe) oeBad++;
      highs   += int'(raw);
      lrHighs += int'(lrclkPin);
      prevRaw = raw;
      prevLr  = lrclkPin;
      @(negedge clk);
      n++;
    end while (!frameStartStb && n < 5000);
    check(n == 64 * int'(v.div), "R4 frame length", n, 64 * int'(v.div));
    check(falls == 64, "R8 falls per frame", falls, 64);
    check(highs == 64 * int'(v.hi), "R3 bit clock high cycles", highs, 64 * int'(v.hi));
    check(edgeBad == 0, "R8 fall strobe alignment", edgeBad, 0);
    check(lrBad == 0, "R4 frame clock change off fall", lrBad, 0);
    check(lineBad == 0, "R7 line equals pin in master", lineBad, 0);
    check(oeBad == 0, "R2 enables in master", oeBad, 0);
    if (v.dsp) begin
      check(lrHighs == int'(v.div), "R6 dsp pulse width", lrHighs, int'(v.div));
      check(startLr == 1'b1, "R6 dsp pulse at frame start", int'(startLr), 1);
    end else begin
      check(lrHighs == 32 * int'(v.div), "R5 frame clock half", lrHighs, 32 * int'(v.div));
      check(startLr == v.pol, "R5 first half level", int'(startLr), int'(v.pol));
    end
  endtask

  task automatic slaveCheck(input int len, input string tag);
    int quietBad = 0, lineBad = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      extBclk  = ~extBclk;
      if (i % 3 == 0) extLrclk = ~extLrclk;
      #1;
      if (bclkOe || lrclkOe || bclkPin || lrclkPin || bitFallStb || frameStartStb)
        quietBad++;
      if (bclkLine != (extBclk ^ bclkInvert) || lrclkLine != extLrclk) lineBad++;
    end
    check(quietBad == 0, {tag, " R10 slave quiet"}, quietBad, 0);
    check(lineBad == 0, {tag, " R7 R10 slave pass-through"}, lineBad, 0);
  endtask

  initial begin
    int n;
    // R1: reset state, with a master code already presented
    ratioCode = 3'd1;
    repeat (3) @(negedge clk);
    check(!bclkOe && !lrclkOe, "R1 enables in reset", int'(bclkOe), 0);
    check(!bclkPin && !lrclkPin, "R1 pins in reset", int'(bclkPin), 0);
    check(!bitFallStb && !frameStartStb, "R1 strobes in reset", int'(bitFallStb), 0);
    ratioCode = 3'd0;
    @(negedge clk);
    rstN = 1'b1;

    // R10, R7: slave pass-through with and without inversion; R2: code 7 is slave
    slaveCheck(20, "code0");
    bclkInvert = 1'b1;
    slaveCheck(20, "code0 inv");
    ratioCode = 3'd7;
    slaveCheck(20, "R2 code7");
    bclkInvert = 1'b0;

    // R11: start from slave
    @(negedge clk);
    ratioCode = 3'd1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check(frameStartStb == 1'b1, "R11 first frame start", int'(frameStartStb), 1);
    check(bclkOe && lrclkOe, "R11 enables on start", int'(bclkOe), 1);

    // Table walk: R2..R8
    foreach (VECS[i]) begin
      ratioCode  = VECS[i].code;
      dspFormat  = VECS[i].dsp;
      lrPolarity = VECS[i].pol;
      bclkInvert = VECS[i].inv;
      countToFrame(n);
      countToFrame(n);
      measureFrame(VECS[i]);
    end

    // R9: ratio change mid-frame completes the running frame first
    ratioCode = 3'd1; dspFormat = 1'b0; lrPolarity = 1'b0; bclkInvert = 1'b0;
    countToFrame(n);
    countToFrame(n);
    repeat (10) @(negedge clk);
    ratioCode = 3'd6;
    countToFrame(n);
    check(n == 128 - 10, "R9 old frame finishes", n, 118);
    measureFrame('{3'd6, 1'b0, 1'b0, 1'b0, 4'd12, 4'd6});

    // R9, R10: switch to slave lands exactly at frame end
    ratioCode = 3'd0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (bclkOe && n < 5000);
    check(n == 768, "R9 slave switch at frame end", n, 768);
    slaveCheck(10, "after master");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule